// File: doc/BRIEF.md
# Bit-Serial Binary-Field Multiplier

This block multiplies two elements of GF(2^83) and reduces the result modulo the fixed polynomial P(x) = x^83 + x^7 + x^4 + x^2 + 1. A caller places both operands on the input buses and raises `start` for one cycle while the block is idle. The block captures the operands, marks itself busy, and then consumes one bit of the second operand per clock. It starts at the highest-order coefficient and works down. Once every bit has been consumed, it pulses `done` and presents the reduced product.

The working register is one bit wider than the field. In each step it folds its top coefficient back through P, adds the first operand when the current multiplier bit is set, and multiplies the sum by x. The answer is the register divided by x, which in hardware is the upper M bits of the register. The field width and the low-order terms of the polynomial are parameters. Another size or another polynomial with the same degree can therefore be built from the same code.

Top module: `gf2m_serial_mul`

## Requirements
- R1: While `rst` is sampled high, the block returns to idle. On the following cycle `busy` and `done` are 0 and `prod` is all zeros.
- R2: A `start` sampled high while `busy` is 0 is accepted. `busy` is 1 in the next cycle and stays 1 for exactly M consecutive cycles (M = 83 by default).
- R3: `done` is high for exactly one cycle. That cycle is the first one with `busy` low after a run, M clock edges after the edge that accepted `start`.
- R4: When `done` is high, `prod` equals opnd_a·opnd_b mod P(x), using the operands captured at the accepted start. Bit i of each bus is the coefficient of x^i, and addition of coefficients is XOR.
- R5: During a run, `start` pulses and any change on `opnd_a` or `opnd_b` have no effect. The run keeps its length, and the product comes from the operands captured at the accepted start.
- R6: From the `done` cycle until the next accepted `start`, `prod` keeps its value, whatever the operand inputs do.
- R7: The corner operands behave as the field requires. Multiplying by 0 gives 0, multiplying by 1 gives the other operand, and x^82·x^82 gives x^164 reduced modulo P.
- R8: The field width M and the polynomial's low-order terms are parameters. With M = 5 and P(x) = x^5 + x^2 + 1 (low terms 5'b00101), every one of the 1024 operand pairs yields the correct reduced product after 5 busy cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication; accepted only while idle |
| opnd_a | input | M | Multiplicand, bit i is the coefficient of x^i |
| opnd_b | input | M | Multiplier, scanned from bit M-1 down to bit 0 |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| prod | output | M | Reduced product; valid from `done` until the next accepted start |

## Verification
Several handshake properties are checked on every cycle by the assertions. These cover the exact run length counted from the accepted start, the single-cycle `done` pulse and its alignment with the falling edge of `busy`, and the rule that a start arriving mid-run cannot cut a run short. They also cover the stability of `prod` while idle and the reset state. Whether the product is arithmetically correct can only be shown by the bench scenarios. These compare against a schoolbook multiply followed by long division by P, on identity and zero operands, high-degree powers of x, random full-width operands, operands disturbed mid-run, and an exhaustive sweep of a 5-bit field.

// File: rtl/gfmul_pkg.sv
package gfmul_pkg;

    // Default field: degree 83, reduction terms x^7 + x^4 + x^2 + 1
    localparam int             GFM_WIDTH    = 83;
    localparam logic [82:0]    GFM_POLY_LOW = 83'h95;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } gfm_phase_e;

    // Control strobes from the sequencer to the datapath
    typedef struct packed {
        logic load;   // capture operands and clear accumulator
        logic step;   // perform one accumulate-and-shift iteration
    } gfm_ctl_t;

    // Width of a counter able to hold the value m
    function automatic int gfm_cnt_w(input int m);
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/gfm_ctrl.sv
module gfm_ctrl
    import gfmul_pkg::*;
#(
    parameter int M = GFM_WIDTH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output gfm_ctl_t ctl,
    output logic     busy,
    output logic     done
);
    localparam int CW = gfm_cnt_w(M);

    gfm_phase_e    phase_q;
    logic [CW-1:0] remain_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            remain_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q  <= PH_RUN;
                        remain_q <= CW'(M);
                    end
                end
                PH_RUN: begin
                    remain_q <= remain_q - 1'b1;
                    if (remain_q == CW'(1)) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.load = (phase_q == PH_IDLE) && start;
        ctl.step = (phase_q == PH_RUN);
    end

    assign busy = (phase_q == PH_RUN);
    assign done = done_q;

endmodule

// File: rtl/gfm_operands.sv
module gfm_operands
    import gfmul_pkg::*;
#(
    parameter int M = GFM_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  gfm_ctl_t     ctl,
    input  logic [M-1:0] a_in,
    input  logic [M-1:0] b_in,
    output logic [M-1:0] a_q,
    output logic         b_top
);
    logic [M-1:0] a_r;
    logic [M-1:0] b_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_r <= '0;
            b_r <= '0;
        end else if (ctl.load) begin
            a_r <= a_in;
            b_r <= b_in;
        end else if (ctl.step) begin
            // expose the next lower coefficient at the top position
            b_r <= {b_r[M-2:0], 1'b0};
        end
    end

    assign a_q   = a_r;
    assign b_top = b_r[M-1];

endmodule

// File: rtl/gfm_acc_step.sv
module gfm_acc_step
    import gfmul_pkg::*;
#(
    parameter int           M        = GFM_WIDTH,
    parameter logic [M-1:0] POLY_LOW = M'(GFM_POLY_LOW)
) (
    input  logic [M:0]   acc_in,
    input  logic [M-1:0] a,
    input  logic         bit_b,
    output logic [M:0]   acc_out
);
    logic         c_top;
    logic [M-1:0] folded;
    logic [M-1:0] summed;

    assign c_top = acc_in[M];

    // Adding c_top*P clears bit M and flips only the bits where P has terms
    for (genvar j = 0; j < M; j++) begin : g_fold
        if (POLY_LOW[j]) begin : g_tap
            assign folded[j] = acc_in[j] ^ c_top;
        end else begin : g_pass
            assign folded[j] = acc_in[j];
        end
    end

    assign summed  = folded ^ (a & {M{bit_b}});
    assign acc_out = {summed, 1'b0};

endmodule

// File: rtl/gf2m_serial_mul.sv
module gf2m_serial_mul
    import gfmul_pkg::*;
#(
    parameter int           M        = GFM_WIDTH,
    parameter logic [M-1:0] POLY_LOW = M'(GFM_POLY_LOW)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [M-1:0] opnd_a,
    input  logic [M-1:0] opnd_b,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] prod
);
    gfm_ctl_t     ctl;
    logic [M-1:0] a_q;
    logic         b_top;
    logic [M:0]   acc_q;
    logic [M:0]   acc_next;

    gfm_ctrl #(.M(M)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    gfm_operands #(.M(M)) u_ops (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .a_in  (opnd_a),
        .b_in  (opnd_b),
        .a_q   (a_q),
        .b_top (b_top)
    );

    gfm_acc_step #(.M(M), .POLY_LOW(POLY_LOW)) u_step (
        .acc_in  (acc_q),
        .a       (a_q),
        .bit_b   (b_top),
        .acc_out (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ctl.load) begin
            acc_q <= '0;
        end else if (ctl.step) begin
            acc_q <= acc_next;
        end
    end

    // Result is the accumulator divided by x
    assign prod = acc_q[M:1];

endmodule

// File: rtl/gf2m_serial_mul_chk.sv
module gf2m_serial_mul_chk #(
    parameter int M = 83
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] prod
);
    localparam int CW = $clog2(M + 1) + 1;

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)                 run_cnt <= '0;
        else if (start && !busy) run_cnt <= '0;
        else if (busy)           run_cnt <= run_cnt + 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && prod == '0));

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r3_run_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == CW'(M)));

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_done_at_fall: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r5_start_no_cut: assert property (@(posedge clk) disable iff (rst)
        (busy && start && run_cnt < CW'(M - 1)) |=> busy);

    a_r6_prod_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(prod));

endmodule

bind gf2m_serial_mul gf2m_serial_mul_chk #(.M(M)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .prod  (prod)
);

// File: tb/gf2m_serial_mul_test.sv
module gf2m_serial_mul_test;
    localparam int BM = 83;
    localparam int SM = 5;
    localparam logic [82:0] BIG_LOW   = 83'h95;   // x^7+x^4+x^2+1
    localparam logic [82:0] SMALL_LOW = 83'h05;   // x^2+1

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic          start = 1'b0;
    logic [BM-1:0] a_in  = '0;
    logic [BM-1:0] b_in  = '0;
    logic          busy, done;
    logic [BM-1:0] prod;

    logic          s_start = 1'b0;
    logic [SM-1:0] s_a = '0;
    logic [SM-1:0] s_b = '0;
    logic          s_busy, s_done;
    logic [SM-1:0] s_prod;

    int checks = 0;
    int fails  = 0;

    gf2m_serial_mul uut (
        .clk(clk), .rst(rst), .start(start), .opnd_a(a_in), .opnd_b(b_in),
        .busy(busy), .done(done), .prod(prod)
    );

    gf2m_serial_mul #(.M(SM), .POLY_LOW(5'b00101)) uut_small (
        .clk(clk), .rst(rst), .start(s_start), .opnd_a(s_a), .opnd_b(s_b),
        .busy(s_busy), .done(s_done), .prod(s_prod)
    );

    // Schoolbook carry-less product, then long division by P
    function automatic logic [82:0] ref_mul(input logic [82:0] a, input logic [82:0] b,
                                            input int m, input logic [82:0] plow);
        logic [165:0] t;
        t = '0;
        for (int i = 0; i < m; i++)
            if (b[i]) t = t ^ ({83'b0, a} << i);
        for (int k = 2 * m - 2; k >= m; k--)
            if (t[k]) t = t ^ ({83'b0, plow} << (k - m)) ^ (166'b1 << k);
        return t[82:0];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [82:0] got, input logic [82:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [82:0] rnd83();
        return {$urandom, $urandom, $urandom};
    endfunction

    // One multiplication on the 83-bit instance; disturb toggles start and operands mid-run
    task automatic run_big(input logic [82:0] a, input logic [82:0] b,
                           input string tag, input bit disturb);
        logic [82:0] exp;
        int n;
        exp = ref_mul(a, b, BM, BIG_LOW);
        @(negedge clk);
        a_in = a; b_in = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2", "busy after start", 83'(busy), 83'd1);
        n = 0;
        while (!done && n < BM + 4) begin
            @(negedge clk);
            n++;
            if (disturb && n == 3) begin
                start = 1'b1; a_in = rnd83(); b_in = rnd83();
            end
            if (disturb && n == 6) start = 1'b0;
        end
        check(n == BM, disturb ? "R5" : "R3", "latency", 83'(n), 83'(BM));
        check(prod === exp, tag, "product", prod, exp);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R3", "done pulse width",
              83'({done, busy}), 83'd0);
        check(prod === exp, "R6", "product held", prod, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1", "idle after reset",
              83'({busy, done}), 83'd0);
        check(prod === '0, "R1", "product cleared", prod, 83'd0);

        // R7 corner operands
        run_big(83'd0, rnd83(), "R7", 1'b0);
        run_big(rnd83(), 83'd0, "R7", 1'b0);
        run_big(83'd1, 83'h5_a5a5_a5a5_a5a5_a5a5_a5a5, "R7", 1'b0);
        run_big(83'h2_3456_789a_bcde_f012_3456, 83'd1, "R7", 1'b0);
        run_big(83'b1 << 82, 83'b1 << 82, "R7", 1'b0);
        run_big(83'b1 << 82, 83'd2, "R7", 1'b0);
        run_big({83{1'b1}}, {83{1'b1}}, "R4", 1'b0);
        for (int i = 0; i < 12; i++) run_big(rnd83(), rnd83(), "R4", 1'b0);

        // R5 start and operand changes during a run
        run_big(rnd83(), rnd83(), "R5", 1'b1);
        run_big(83'b1 << 82, {83{1'b1}}, "R5", 1'b1);

        // R6 operand inputs change while idle
        begin
            logic [82:0] held;
            held = prod;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                a_in = rnd83(); b_in = rnd83();
            end
            @(negedge clk);
            check(prod === held, "R6", "idle operand change", prod, held);
        end

        // R8 exhaustive sweep of the 5-bit field
        for (int x = 0; x < 32; x++) begin
            for (int y = 0; y < 32; y++) begin
                logic [82:0] exp;
                int n;
                exp = ref_mul(83'(x), 83'(y), SM, SMALL_LOW);
                @(negedge clk);
                s_a = SM'(x); s_b = SM'(y); s_start = 1'b1;
                @(negedge clk);
                s_start = 1'b0;
                n = 0;
                while (!s_done && n < SM + 4) begin
                    @(negedge clk);
                    n++;
                end
                check(n == SM && 83'(s_prod) === exp, "R8", "small field product",
                      {78'(n), s_prod}, {78'(SM), exp[4:0]});
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R3: watchdog expired, got %0d cycles expected fewer", 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule